// File: doc/BRIEF.md
# Interlaced Raster Sync and Clamp Generator

This block walks an interlaced 525-line raster one pixel at a time and produces the timing strobes that go with it. These are a horizontal sync, a vertical sync, a simple composite sync and a clamp pulse for a downstream black-level restorer. The raster advances only on clocks where a pixel enable is high, so a fast system clock can drive a slower pixel rate.

Horizontal and composite sync leave the block on one shared pin, and a select input chooses which of the two drives it. The clamp pulse can sit on the back porch, just after horizontal sync, or on the front porch, just before the next one. A 3-bit sign-magnitude shift moves it up to three pixels earlier or later. Every output is registered at the same stage, so all strobes change on the same enabled edge.

Top module: `video_sync_gen`

## Requirements
- R1: While reset is high at a clock edge, every output goes low and the raster position returns to pixel 0 of line 1. The first enabled edge after reset therefore drives horizontal sync high.
- R2: The position advances by one pixel only on edges where the pixel enable is high. On any other edge all outputs keep their values.
- R3: Pixel count runs 0 to LINE_CLKS-1 and then moves to the next line. Line count runs 1 to LINES and then returns to 1.
- R4: Horizontal sync is high for pixel positions 0 to HSYNC_CLKS-1 of every line.
- R5: Field 1 covers lines 1 to (LINES+1)/2 and field 2 covers the remaining lines, numbered from 1 again. Vertical sync is high for whole field lines VS_FIRST to VS_LAST (defaults 4 to 6) in both fields.
- R6: With the composite select low, the shared sync pin carries horizontal sync. With it high, the pin carries horizontal sync XOR vertical sync.
- R7: With the porch select high (back porch), the clamp pulse, unshifted, is CLAMP_LEN pixels long and starts at pixel HSYNC_CLKS+BP_GAP.
- R8: With the porch select low (front porch), the clamp pulse, unshifted, is CLAMP_LEN pixels long and starts at pixel LINE_CLKS-FP_GAP.
- R9: The shift field moves the whole clamp pulse by its magnitude, bits 1:0 (0 to 3 pixels). Bit 2 set means earlier and bit 2 clear means later. A magnitude of 0 leaves the pulse at its default position.
- R10: Each output changes on an enabled edge and reflects the position and the control inputs at that edge. All outputs have the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel enable; the raster advances one pixel when high |
| compSel | input | 1 | 1: shared pin carries composite sync; 0: horizontal sync |
| porchSel | input | 1 | 1: clamp on back porch; 0: clamp on front porch |
| clampShift | input | 3 | Clamp shift: bit 2 direction (1 earlier), bits 1:0 magnitude |
| hcSyncOut | output | 1 | Shared horizontal / composite sync, active high |
| vSyncOut | output | 1 | Vertical sync, active high |
| clampOut | output | 1 | Clamp pulse, active high |

## Verification
Every output is due exactly one enabled edge after the position and controls that determine it, and it holds through edges where the enable is low. The bench keeps its own raster position and, at each falling edge, pushes the value it predicts for the next rising edge. It does this whether or not the enable is high. A monitor pops that prediction a quarter period after the rising edge and compares all three pins. The controls change with the line number, and the enable drops on a regular cadence, so the run covers both fields, both porches and all eight shift codes.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Strobes decoded by the control from the raster position, consumed by the datapath.
  typedef struct packed {
    logic hsync;
    logic vsync;
    logic clamp;
  } vsgStrobe_t;

endpackage

// File: rtl/vsg_control.sv
module vsg_control
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS  = 858,
  parameter int LINES      = 525,
  parameter int HSYNC_CLKS = 64,
  parameter int VS_FIRST   = 4,
  parameter int VS_LAST    = 6,
  parameter int CLAMP_LEN  = 16,
  parameter int BP_GAP     = 8,
  parameter int FP_GAP     = 24,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pixEn,
  input  logic            porchSel,
  input  logic [2:0]      clampShift,
  output logic [HW-1:0]   hCount,
  output logic [LW-1:0]   lineNum,
  output vsgStrobe_t      strobes
);

  localparam int FIELD1_LINES = (LINES + 1) / 2;
  localparam int CW           = HW + 2;
  localparam logic [CW-1:0] BACK_BASE  = CW'(HSYNC_CLKS + BP_GAP);
  localparam logic [CW-1:0] FRONT_BASE = CW'(LINE_CLKS - FP_GAP);
  localparam logic [CW-1:0] CLAMP_SPAN = CW'(CLAMP_LEN);

  logic lineEnd;
  logic frameEnd;
  logic [LW-1:0] fieldLine;
  logic [CW-1:0] clampBase;
  logic [CW-1:0] clampStart;
  logic [CW-1:0] clampStop;
  logic [CW-1:0] hWide;

  assign lineEnd  = (hCount == HW'(LINE_CLKS - 1));
  assign frameEnd = (lineNum == LW'(LINES));

  // Pixel and line counters, stepping only on enabled clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      hCount  <= '0;
      lineNum <= LW'(1);
    end else if (pixEn) begin
      if (lineEnd) begin
        hCount  <= '0;
        lineNum <= frameEnd ? LW'(1) : lineNum + LW'(1);
      end else begin
        hCount <= hCount + HW'(1);
      end
    end
  end

  // Line number within the current field.
  always_comb begin
    if (lineNum > LW'(FIELD1_LINES)) fieldLine = lineNum - LW'(FIELD1_LINES);
    else                             fieldLine = lineNum;
  end

  // Clamp window: porch base, then sign-magnitude shift.
  always_comb begin
    clampBase = porchSel ? BACK_BASE : FRONT_BASE;
    if (clampShift[2]) clampStart = clampBase - CW'(clampShift[1:0]);
    else               clampStart = clampBase + CW'(clampShift[1:0]);
    clampStop = clampStart + CLAMP_SPAN;
    hWide     = CW'(hCount);
  end

  always_comb begin
    strobes.hsync = (hCount < HW'(HSYNC_CLKS));
    strobes.vsync = (fieldLine >= LW'(VS_FIRST)) && (fieldLine <= LW'(VS_LAST));
    strobes.clamp = (hWide >= clampStart) && (hWide < clampStop);
  end

endmodule

// File: rtl/vsg_datapath.sv
module vsg_datapath
  import vsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pixEn,
  input  logic       compSel,
  input  vsgStrobe_t strobes,
  output logic       hsyncQ,
  output logic       hcSyncOut,
  output logic       vSyncOut,
  output logic       clampOut
);

  logic sharedNext;

  assign sharedNext = compSel ? (strobes.hsync ^ strobes.vsync) : strobes.hsync;

  // One register stage for every output keeps them mutually aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncQ    <= 1'b0;
      hcSyncOut <= 1'b0;
      vSyncOut  <= 1'b0;
      clampOut  <= 1'b0;
    end else if (pixEn) begin
      hsyncQ    <= strobes.hsync;
      hcSyncOut <= sharedNext;
      vSyncOut  <= strobes.vsync;
      clampOut  <= strobes.clamp;
    end
  end

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS  = 858,
  parameter int LINES      = 525,
  parameter int HSYNC_CLKS = 64,
  parameter int VS_FIRST   = 4,
  parameter int VS_LAST    = 6,
  parameter int CLAMP_LEN  = 16,
  parameter int BP_GAP     = 8,
  parameter int FP_GAP     = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pixEn,
  input  logic       compSel,
  input  logic       porchSel,
  input  logic [2:0] clampShift,
  output logic       hcSyncOut,
  output logic       vSyncOut,
  output logic       clampOut
);

  localparam int HW = $clog2(LINE_CLKS);
  localparam int LW = $clog2(LINES + 1);

  vsgStrobe_t    strobes;
  logic [HW-1:0] hCount;
  logic [LW-1:0] lineNum;
  logic          hsyncQ;

  vsg_control #(
    .LINE_CLKS(LINE_CLKS), .LINES(LINES), .HSYNC_CLKS(HSYNC_CLKS),
    .VS_FIRST(VS_FIRST), .VS_LAST(VS_LAST), .CLAMP_LEN(CLAMP_LEN),
    .BP_GAP(BP_GAP), .FP_GAP(FP_GAP)
  ) u_control (
    .clk(clk), .rst(rst), .pixEn(pixEn), .porchSel(porchSel),
    .clampShift(clampShift), .hCount(hCount), .lineNum(lineNum),
    .strobes(strobes)
  );

  vsg_datapath u_datapath (
    .clk(clk), .rst(rst), .pixEn(pixEn), .compSel(compSel),
    .strobes(strobes), .hsyncQ(hsyncQ), .hcSyncOut(hcSyncOut),
    .vSyncOut(vSyncOut), .clampOut(clampOut)
  );

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker
  import vsg_pkg::*;
#(
  parameter int LINE_CLKS = 858,
  parameter int LINES     = 525,
  parameter int HW        = 10,
  parameter int LW        = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pixEn,
  input vsgStrobe_t    strobes,
  input logic [HW-1:0] hCount,
  input logic [LW-1:0] lineNum,
  input logic          hsyncQ,
  input logic          hcSyncOut,
  input logic          vSyncOut,
  input logic          clampOut
);

  logic seenRst = 1'b0;
  always_ff @(posedge clk) if (rst) seenRst <= 1'b1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    (seenRst && $past(rst)) |-> (!hcSyncOut && !vSyncOut && !clampOut));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && !$past(pixEn)) |->
      ($stable(hcSyncOut) && $stable(vSyncOut) && $stable(clampOut)));

  a_r3_pixel_range: assert property (@(posedge clk) disable iff (rst)
    hCount < HW'(LINE_CLKS));

  a_r3_line_range: assert property (@(posedge clk) disable iff (rst)
    (lineNum >= LW'(1)) && (lineNum <= LW'(LINES)));

  // R6: outside vertical sync the shared pin equals horizontal sync in either mode.
  a_r6_shared_matches_h: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && $past(pixEn) && !$past(strobes.vsync)) |->
      (hcSyncOut == $past(strobes.hsync)));

  a_r10_vsync_latency: assert property (@(posedge clk) disable iff (rst)
    (seenRst && !$past(rst) && $past(pixEn)) |-> (vSyncOut == $past(strobes.vsync)));

  a_r7_clamp_clear_of_hsync: assert property (@(posedge clk) disable iff (rst)
    !(clampOut && hsyncQ));

endmodule

bind video_sync_gen vsg_checker #(
  .LINE_CLKS(LINE_CLKS), .LINES(LINES), .HW(HW), .LW(LW)
) u_vsg_checker (
  .clk(clk), .rst(rst), .pixEn(pixEn), .strobes(strobes),
  .hCount(hCount), .lineNum(lineNum), .hsyncQ(hsyncQ),
  .hcSyncOut(hcSyncOut), .vSyncOut(vSyncOut), .clampOut(clampOut)
);

// File: tb/video_sync_gen_test.sv
module video_sync_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_LINE  = 100;
  localparam int T_LINES = 525;
  localparam int T_HS    = 10;
  localparam int T_VS0   = 4;
  localparam int T_VS1   = 6;
  localparam int T_CLEN  = 16;
  localparam int T_BP    = 8;
  localparam int T_FP    = 24;
  localparam int FIELD1  = (T_LINES + 1) / 2;
  localparam int RUN_STEPS = T_LINE * T_LINES + 6 * T_LINE;
  localparam int WATCHDOG  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixEn = 1'b0;
  logic compSel = 1'b0;
  logic porchSel = 1'b0;
  logic [2:0] clampShift = 3'b000;
  logic hcSyncOut, vSyncOut, clampOut;

  typedef struct {
    logic s;
    logic v;
    logic c;
    int   l;
    int   h;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  video_sync_gen #(
    .LINE_CLKS(T_LINE), .LINES(T_LINES), .HSYNC_CLKS(T_HS),
    .VS_FIRST(T_VS0), .VS_LAST(T_VS1), .CLAMP_LEN(T_CLEN),
    .BP_GAP(T_BP), .FP_GAP(T_FP)
  ) uut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .compSel(compSel),
    .porchSel(porchSel), .clampShift(clampShift),
    .hcSyncOut(hcSyncOut), .vSyncOut(vSyncOut), .clampOut(clampOut)
  );

  task automatic check(input string tag, input logic got, input logic exp, input int l, input int h);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b (line %0d pixel %0d)", tag, got, exp, l, h);
    end
  endtask

  // Monitor: compares a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (running && q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        check("R2 R3 R4 R6 R10 shared sync", hcSyncOut, e.s, e.l, e.h);
        check("R2 R3 R5 R10 vertical sync", vSyncOut, e.v, e.l, e.h);
        check("R2 R7 R8 R9 R10 clamp", clampOut, e.c, e.l, e.h);
      end
    end
  end

  // Driver: reference raster model, pushes the value due at the next rising edge.
  initial begin
    int h;
    int l;
    int step;
    int cyc;
    expItem_t held;
    h = 0; l = 1; step = 0; cyc = 0;
    held = '{s: 1'b0, v: 1'b0, c: 1'b0, l: 1, h: 0};
    repeat (4) @(negedge clk);
    // R1: outputs low while reset is held
    check("R1 reset shared sync", hcSyncOut, 1'b0, 0, 0);
    check("R1 reset vertical sync", vSyncOut, 1'b0, 0, 0);
    check("R1 reset clamp", clampOut, 1'b0, 0, 0);
    rst = 1'b0;
    running = 1;
    while (step < RUN_STEPS) begin
      int fl;
      int base;
      int start;
      logic hs;
      logic vs;
      cyc++;
      pixEn      = (cyc % 7) != 3;
      compSel    = l[0];
      porchSel   = l[1];
      clampShift = 3'((l >> 2) & 7);
      if (pixEn) begin
        hs = (h < T_HS);
        fl = (l > FIELD1) ? l - FIELD1 : l;
        vs = (fl >= T_VS0) && (fl <= T_VS1);
        base = porchSel ? (T_HS + T_BP) : (T_LINE - T_FP);
        start = clampShift[2] ? base - int'(clampShift[1:0]) : base + int'(clampShift[1:0]);
        held.s = compSel ? (hs ^ vs) : hs;
        held.v = vs;
        held.c = (h >= start) && (h < start + T_CLEN);
        held.l = l;
        held.h = h;
        h++;
        if (h == T_LINE) begin
          h = 0;
          l = (l == T_LINES) ? 1 : l + 1;
        end
        step++;
      end
      q.push_back(held);
      @(negedge clk);
    end
    pixEn = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
  end

  // Watchdog and summary.
  initial begin
    int n;
    n = 0;
    while (!finished && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", n);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule